// File: doc/BRIEF.md
# Lazy FPU Context Ownership Controller

This controller decides when floating-point register state has to move between tasks. It holds two pieces of state. The first is the context of the running task: its identifier and its floating-point enable bit, which the kernel reloads on every task switch. The second is the identity of the task whose values currently sit in the floating-point registers, or a mark that no task owns them. A task switch on its own moves no floating-point state. The registers are assumed unused until the first floating-point instruction after the switch.

When a floating-point instruction is presented, one of three things happens. If the running task has floating-point disabled, the instruction is refused and a trap request is raised. If the task is enabled and already owns the registers, the instruction proceeds in the same cycle. If the task is enabled but another task, or no task, owns the registers, the controller stalls the instruction and asks the kernel for a transfer. The request carries an optional save of the old owner and a load for the new one. When the kernel acknowledges, the running task becomes the owner and the stalled instruction proceeds.

The state machine has two states. RUN is the reset state: it grants, traps or starts a transfer. XFER holds the transfer request until acknowledge. The transitions are: RUN to XFER (`start`) on an enabled, unowned floating-point issue; XFER to RUN (`commit`) on `xfer_ack`; otherwise each state stays where it is.

Top module: `fpu_owner_ctl`

## Requirements
- R1: After reset, no task owns the registers, `xfer_req` and `save_en` are 0, and the running task counts as disabled, so a floating-point issue traps.
- R2: In RUN, `fp_issue` with the running task disabled drives `fp_trap`=1 and `fp_go`=0 in the same cycle. No transfer starts and the owner is unchanged.
- R3: In RUN, `fp_issue` from an enabled task that owns the registers drives `fp_go`=1 and `fp_trap`=0 in the same cycle, with no transfer and no stall.
- R4: In RUN, `fp_issue` from an enabled task that does not own the registers gives `fp_go`=0 and `fp_trap`=0. From the next cycle, `xfer_req`=1 and `load_id` is the running task's identifier.
- R5: At the start of a transfer, `save_en` is 1 and `save_id` is the old owner's identifier when an owner exists. When no task owns the registers, `save_en` is 0.
- R6: While `xfer_req` is 1 and `xfer_ack` is 0, the request stays up with `save_en`, `save_id` and `load_id` unchanged, and `fp_go` stays 0.
- R7: In the cycle after `xfer_ack` is seen with `xfer_req` high, `xfer_req` is 0 and the loaded task is the owner. A still-present `fp_issue` from that task then gets `fp_go`=1.
- R8: `ctx_load` takes effect from the next cycle. A task switch alone never raises `xfer_req`, and switching back to the owning task needs no transfer.
- R9: At most one transfer starts between two `ctx_load` pulses.
- R10: A trapped issue leaves ownership untouched. The next transfer saves the task that owned the registers before the trap.
- R11: `xfer_ack` while no request is pending is ignored: no request appears and ownership is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_load | input | 1 | Task switch: load the running-task context |
| ctx_task_id | input | 8 | Identifier of the task being switched in |
| ctx_fp_en | input | 1 | Floating-point enable bit of that task |
| fp_issue | input | 1 | A floating-point instruction is presented |
| fp_go | output | 1 | The presented instruction may execute this cycle |
| fp_trap | output | 1 | Trap request: floating point disabled for the running task |
| xfer_ack | input | 1 | Kernel has finished the requested save/load |
| xfer_req | output | 1 | Transfer request, held until acknowledged |
| save_en | output | 1 | The transfer includes a save of the old owner |
| save_id | output | 8 | Task whose state is to be saved |
| load_id | output | 8 | Task whose state is to be loaded |

## Verification
The hardest situation to reach is a transfer whose save target depends on history several switches back. A disabled task traps while a third task owns the registers, and only a later enabled task reveals through `save_id` that the trap changed nothing. The bench walks a long deterministic sequence of switches over four identifiers, including 0x00 and 0xFF, and mixes enable bits. A bench model tracks the owner. Acknowledge latency varies from zero to two extra cycles, and some switches issue a second instruction, which must pass without a new transfer.

// File: rtl/fpu_own_pkg.sv
package fpu_own_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_XFER = 1'b1
    } own_state_e;
endpackage

// File: rtl/fpu_task_ctx.sv
module fpu_task_ctx #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [ID_W-1:0] ld_id,
    input  logic            ld_en,
    output logic [ID_W-1:0] cur_id,
    output logic            cur_en
);
    // Running-task context: reloaded on every switch, disabled out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_id <= '0;
            cur_en <= 1'b0;
        end else if (ld) begin
            cur_id <= ld_id;
            cur_en <= ld_en;
        end
    end
endmodule

// File: rtl/fpu_owner_track.sv
module fpu_owner_track #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [ID_W-1:0] new_id,
    input  logic [ID_W-1:0] cur_id,
    output logic [ID_W-1:0] own_id,
    output logic            own_valid,
    output logic            is_owner
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_id    <= '0;
            own_valid <= 1'b0;
        end else if (commit) begin
            own_id    <= new_id;
            own_valid <= 1'b1;
        end
    end

    always_comb is_owner = own_valid && (own_id == cur_id);

    // R7: a commit installs the requested task as valid owner
    a_r7_commit_owner: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (own_valid && own_id == $past(new_id)));

    // R10: without a commit the owner never moves
    a_r10_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(own_id) && $stable(own_valid)));
endmodule

// File: rtl/fpu_owner_ctl.sv
module fpu_owner_ctl
    import fpu_own_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctx_load,
    input  logic [ID_W-1:0] ctx_task_id,
    input  logic            ctx_fp_en,
    input  logic            fp_issue,
    output logic            fp_go,
    output logic            fp_trap,
    input  logic            xfer_ack,
    output logic            xfer_req,
    output logic            save_en,
    output logic [ID_W-1:0] save_id,
    output logic [ID_W-1:0] load_id
);
    own_state_e      state, state_nx;
    logic [ID_W-1:0] cur_id, own_id;
    logic            cur_en, own_valid, is_owner;
    logic            start, commit;
    logic            save_en_q;
    logic [ID_W-1:0] save_id_q, load_id_q;
    logic [1:0]      starts_this_switch;

    fpu_task_ctx #(.ID_W(ID_W)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ctx_load),
        .ld_id  (ctx_task_id),
        .ld_en  (ctx_fp_en),
        .cur_id (cur_id),
        .cur_en (cur_en)
    );

    fpu_owner_track #(.ID_W(ID_W)) u_own (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .new_id    (load_id_q),
        .cur_id    (cur_id),
        .own_id    (own_id),
        .own_valid (own_valid),
        .is_owner  (is_owner)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Next state: start (RUN->XFER), commit (XFER->RUN)
    always_comb begin
        state_nx = state;
        start    = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (fp_issue && cur_en && !is_owner) begin
                    state_nx = ST_XFER;
                    start    = 1'b1;
                end
            end
            ST_XFER: begin
                if (xfer_ack) begin
                    state_nx = ST_RUN;
                    commit   = 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        fp_go    = 1'b0;
        fp_trap  = 1'b0;
        xfer_req = 1'b0;
        unique case (state)
            ST_RUN: begin
                fp_trap = fp_issue && !cur_en;
                fp_go   = fp_issue && cur_en && is_owner;
            end
            ST_XFER: xfer_req = 1'b1;
        endcase
        save_en = save_en_q;
        save_id = save_id_q;
        load_id = load_id_q;
    end

    // Transfer descriptor captured on start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save_en_q <= 1'b0;
            save_id_q <= '0;
            load_id_q <= '0;
        end else if (start) begin
            save_en_q <= own_valid;
            save_id_q <= own_id;
            load_id_q <= cur_id;
        end
    end

    // Transfers started since the last task switch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       starts_this_switch <= '0;
        else if (ctx_load)                starts_this_switch <= '0;
        else if (start && starts_this_switch != 2'd3)
            starts_this_switch <= starts_this_switch + 2'd1;
    end

    // R2: trap and grant are exclusive
    a_r2_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
        fp_trap |-> (!fp_go && !xfer_req));

    // R4: an enabled non-owner issue raises a request next cycle for itself
    a_r4_req_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_req && fp_issue && cur_en && !is_owner) |=>
            (xfer_req && load_id == $past(cur_id)));

    // R5: a save is requested only for a task other than the one loaded
    a_r5_save_other: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && save_en) |-> (save_id != load_id));

    // R6: pending request holds its descriptor and blocks issue
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=>
            (xfer_req && $stable(load_id) && $stable(save_id) && $stable(save_en)));

    a_r6_no_go: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !fp_go);

    // R7: acknowledge drops the request
    a_r7_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack) |=> !xfer_req);

    // R9: no second transfer inside one task switch
    a_r9_one_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (starts_this_switch == 2'd0));
endmodule

// File: tb/tb_fpu_owner_ctl.sv
module tb_fpu_owner_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctx_load = 1'b0;
    logic [7:0] ctx_task_id = '0;
    logic       ctx_fp_en = 1'b0;
    logic       fp_issue = 1'b0;
    logic       xfer_ack = 1'b0;
    logic       fp_go, fp_trap, xfer_req, save_en;
    logic [7:0] save_id, load_id;

    int errors = 0;
    int checks = 0;

    // Bench model
    logic [7:0] m_cur = '0;
    logic       m_en = 1'b0;
    logic [7:0] m_own = '0;
    logic       m_valid = 1'b0;

    always #2 clk = ~clk;

    fpu_owner_ctl #(.ID_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_task_id(ctx_task_id),
        .ctx_fp_en(ctx_fp_en), .fp_issue(fp_issue), .fp_go(fp_go), .fp_trap(fp_trap),
        .xfer_ack(xfer_ack), .xfer_req(xfer_req), .save_en(save_en),
        .save_id(save_id), .load_id(load_id)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] idsel(input int n);
        case (n)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h5A;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic do_switch(input logic [7:0] id, input logic en);
        @(negedge clk);
        ctx_load = 1'b1; ctx_task_id = id; ctx_fp_en = en;
        @(posedge clk);
        @(negedge clk);
        ctx_load = 1'b0;
        m_cur = id; m_en = en;
        #1;
        chk("R8 switch alone raises no request", xfer_req, 0);
    endtask

    task automatic do_fp(input int wait_cyc);
        @(negedge clk);
        fp_issue = 1'b1;
        #1;
        if (!m_en) begin
            chk("R2 trap when disabled", fp_trap, 1);
            chk("R2 no go when disabled", fp_go, 0);
            @(negedge clk);
            chk("R2 trap starts no transfer", xfer_req, 0);
        end else if (m_valid && m_own == m_cur) begin
            chk("R3 owner goes at once", fp_go, 1);
            chk("R3 owner no trap", fp_trap, 0);
            @(negedge clk);
            chk("R3/R9 owner no transfer", xfer_req, 0);
        end else begin
            chk("R4 stall non-owner", {fp_go, fp_trap}, 0);
            @(negedge clk);
            #1;
            chk("R4 request raised", xfer_req, 1);
            chk("R4 load_id", load_id, m_cur);
            chk("R5 save_en", save_en, m_valid);
            if (m_valid) chk("R5/R10 save_id old owner", save_id, m_own);
            for (int k = 0; k < wait_cyc; k++) begin
                @(negedge clk);
                #1;
                chk("R6 request held", xfer_req, 1);
                chk("R6 load_id held", load_id, m_cur);
                chk("R6 no go while pending", fp_go, 0);
            end
            xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
            m_own = m_cur; m_valid = 1'b1;
            #1;
            chk("R7 request dropped", xfer_req, 0);
            chk("R7 stalled issue proceeds", fp_go, 1);
        end
        fp_issue = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 no request after reset", xfer_req, 0);
        chk("R1 save_en after reset", save_en, 0);
        fp_issue = 1'b1;
        #1;
        chk("R1 disabled after reset traps", fp_trap, 1);
        fp_issue = 1'b0;

        // R11 stray acknowledge ignored
        do_switch(8'h01, 1'b1);
        @(negedge clk);
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        #1;
        chk("R11 stray ack no request", xfer_req, 0);
        do_fp(1);  // R5: first transfer from invalid owner, save_en expected 0

        // R10 trap leaves owner, R8 switch back to owner needs no transfer
        do_switch(8'h5A, 1'b0);
        do_fp(0);
        do_switch(8'h01, 1'b1);
        do_fp(0);
        do_switch(8'hFF, 1'b1);
        do_fp(2);

        // Sweep of switches, enables and acknowledge latencies
        for (int i = 0; i < 120; i++) begin
            do_switch(idsel((i * 3 + i / 4) % 4), (i % 5) != 2);
            if (i % 7 == 3) continue;
            do_fp(i % 3);
            if (i % 4 == 0) do_fp(1);  // R9 second issue in the same switch
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule